// File: doc/BRIEF.md
# Iterative Triple-DES Engine

This block encrypts or decrypts one 64-bit block with the triple DES construction. A single Feistel round unit does all the work: it is run for 16 rounds in each of three back-to-back DES passes, so one block takes 48 round cycles. Each round uses a 48-bit subkey produced on the fly from the key for that pass. The pass keys are chosen from three 64-bit key inputs according to the direction and the key option. The initial permutation is applied once when the block is loaded, and the final permutation is applied once to the held state after the last pass.

A caller presents the block, the keys and the two option bits, then pulses `start` while the engine is idle. The engine raises `busy` and ignores its inputs until it finishes. It then pulses `done` for one cycle and holds the result on `data_out`. In two-key operation only `key_a` and `key_b` matter, and `key_a` takes the place of the third key. Chaining modes and key parity checks belong to the surrounding logic.

Top module: `tdea_core`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are both 0.
- R2: When `start` is 1 at a rising edge while `busy` is 0, the engine takes the block, keys and option bits. `busy` is 1 from the next cycle on.
- R3: Bit 63 of a 64-bit value is the first bit of the DES bit order. With `three_key`=1, `decrypt`=0 and all three keys equal to 133457799BBCDFF1, the block 0123456789ABCDEF encrypts to 85E813540F0AB405, which is the single-DES result.
- R4: With `decrypt`=0 the passes run as encrypt under key 1, decrypt under key 2, encrypt under key 3. With `decrypt`=1 they run as decrypt under key 3, encrypt under key 2, decrypt under key 1. Encrypting a block and then decrypting the result with the same keys and option gives back the original block.
- R5: With `three_key`=0, `key_c` has no effect and `key_a` is used as key 3.
- R6: A `start` pulse while `busy` is 1 is ignored. Changes to `data_in`, the keys or the option bits while the engine is busy do not change the result or its timing.
- R7: `done` is high for exactly one cycle. `data_out` keeps the result until the next accepted `start`.
- R8: `done` is 1 in the cycle that follows the 48th rising edge after the accepting edge. `busy` drops in that same cycle.
- R9: With `decrypt`=1, `three_key`=1 and all keys equal to 133457799BBCDFF1, the block 85E813540F0AB405 decrypts to 0123456789ABCDEF.
- R10: Key bits 0, 8, 16, 24, 32, 40, 48 and 56 (the parity bits) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block when idle |
| decrypt | input | 1 | 1 selects decryption, 0 selects encryption |
| three_key | input | 1 | 1 selects three independent keys, 0 selects two-key operation |
| data_in | input | 64 | Input block |
| key_a | input | 64 | Key 1 |
| key_b | input | 64 | Key 2 |
| key_c | input | 64 | Key 3, used only when `three_key`=1 |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when the result is ready |
| data_out | output | 64 | Result block, valid from `done` until the next accepted start |

## Verification
From the ports it is hard to tell whether the pass keys are applied in the right order with the right directions, or whether the halves are handed across the pass boundaries correctly. A plain round trip hides an order that is wrong in the same way in both directions. The stimulus therefore makes two of the three keys equal, so that one pair of passes cancels. The survivor must then be a single-DES answer known in advance, and it sits in pass 1 for one key pairing and in pass 3 for the other. A second hard case is a new request arriving mid-block. The bench pulses `start` and changes every other input partway through a run, then checks both the answer and the cycle in which `done` appears.

// File: rtl/tdea_pkg.sv
package tdea_pkg;

    localparam int BLK_W      = 64;
    localparam int HALF_W     = BLK_W / 2;
    localparam int CD_W       = 56;
    localparam int CD_HALF_W  = CD_W / 2;
    localparam int SUB_W      = 48;
    localparam int SBOX_CNT   = 8;
    localparam int ROUNDS     = 16;
    localparam int PASSES     = 3;
    localparam int RND_W      = $clog2(ROUNDS);
    localparam int PASS_W     = $clog2(PASSES + 1);

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } pass_dir_e;

    typedef struct packed {
        logic [HALF_W-1:0] left;
        logic [HALF_W-1:0] right;
    } halves_t;

    localparam int P_TAB [32] = '{16, 7, 20, 21, 29, 12, 28, 17,
                                  1, 15, 23, 26,  5, 18, 31, 10,
                                  2,  8, 24, 14, 32, 27,  3,  9,
                                 19, 13, 30,  6, 22, 11,  4, 25};

    localparam int PC1_TAB [56] = '{57, 49, 41, 33, 25, 17,  9,
                                     1, 58, 50, 42, 34, 26, 18,
                                    10,  2, 59, 51, 43, 35, 27,
                                    19, 11,  3, 60, 52, 44, 36,
                                    63, 55, 47, 39, 31, 23, 15,
                                     7, 62, 54, 46, 38, 30, 22,
                                    14,  6, 61, 53, 45, 37, 29,
                                    21, 13,  5, 28, 20, 12,  4};

    localparam int PC2_TAB [48] = '{14, 17, 11, 24,  1,  5,
                                     3, 28, 15,  6, 21, 10,
                                    23, 19, 12,  4, 26,  8,
                                    16,  7, 27, 20, 13,  2,
                                    41, 52, 31, 37, 47, 55,
                                    30, 40, 51, 45, 33, 48,
                                    44, 49, 39, 56, 34, 53,
                                    46, 42, 50, 36, 29, 32};

    // Each entry holds 64 nibbles, row-major (row 0 col 0 is the top nibble).
    localparam logic [255:0] SBOX_TAB [SBOX_CNT] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D70934A6285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    // Source bit (1-based, first bit = 1) of output position pos of the initial permutation.
    function automatic int ip_source(input int pos);
        int row;
        int col;
        int base;
        row  = pos / 8;
        col  = pos % 8;
        base = (row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4));
        return base - 8 * col;
    endfunction

    function automatic logic [BLK_W-1:0] initial_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int i = 0; i < BLK_W; i++) begin
            y[BLK_W-1-i] = x[BLK_W-ip_source(i)];
        end
        return y;
    endfunction

    function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int i = 0; i < BLK_W; i++) begin
            y[BLK_W-ip_source(i)] = x[BLK_W-1-i];
        end
        return y;
    endfunction

    function automatic logic [SUB_W-1:0] expand(input logic [HALF_W-1:0] r);
        logic [SUB_W-1:0] y;
        int src;
        for (int g = 0; g < SBOX_CNT; g++) begin
            for (int k = 0; k < 6; k++) begin
                src = 4 * g + k;
                if (src == 0)  src = HALF_W;
                if (src == 33) src = 1;
                y[SUB_W-1-(6*g+k)] = r[HALF_W-src];
            end
        end
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] pbox(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        for (int i = 0; i < HALF_W; i++) begin
            y[HALF_W-1-i] = x[HALF_W-P_TAB[i]];
        end
        return y;
    endfunction

    function automatic logic [CD_W-1:0] choice1(input logic [BLK_W-1:0] k);
        logic [CD_W-1:0] y;
        for (int i = 0; i < CD_W; i++) begin
            y[CD_W-1-i] = k[BLK_W-PC1_TAB[i]];
        end
        return y;
    endfunction

    function automatic logic [SUB_W-1:0] choice2(input logic [CD_W-1:0] cd);
        logic [SUB_W-1:0] y;
        for (int i = 0; i < SUB_W; i++) begin
            y[SUB_W-1-i] = cd[CD_W-PC2_TAB[i]];
        end
        return y;
    endfunction

    // Rounds 1, 2, 9 and 16 (indices 0, 1, 8, 15) shift by one, the rest by two.
    function automatic logic shift_is_one(input logic [RND_W-1:0] rnd);
        return (rnd == 4'd0) || (rnd == 4'd1) || (rnd == 4'd8) || (rnd == 4'd15);
    endfunction

    function automatic logic [3:0] sbox_lookup(input int idx, input logic [5:0] x);
        logic [5:0] n;
        n = {x[5], x[0], x[4:1]};
        return SBOX_TAB[idx][255 - 4 * n -: 4];
    endfunction

endpackage

// File: rtl/tdea_sbox.sv
module tdea_sbox
    import tdea_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [5:0] sel,
    output logic [3:0] val
);
    always_comb begin
        val = sbox_lookup(IDX, sel);
    end
endmodule

// File: rtl/tdea_feistel.sv
module tdea_feistel
    import tdea_pkg::*;
(
    input  logic [HALF_W-1:0] half_in,
    input  logic [SUB_W-1:0]  subkey,
    output logic [HALF_W-1:0] f_out
);
    logic [SUB_W-1:0]  mixed;
    logic [HALF_W-1:0] subst;

    always_comb begin
        mixed = expand(half_in) ^ subkey;
    end

    for (genvar g = 0; g < SBOX_CNT; g++) begin : g_sbox
        tdea_sbox #(.IDX(g)) u_sbox (
            .sel (mixed[SUB_W-1-6*g -: 6]),
            .val (subst[HALF_W-1-4*g -: 4])
        );
    end

    always_comb begin
        f_out = pbox(subst);
    end
endmodule

// File: rtl/tdea_keysched.sv
module tdea_keysched
    import tdea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BLK_W-1:0]  load_key,
    input  logic              step,
    input  pass_dir_e         dir,
    input  logic [RND_W-1:0]  rnd,
    output logic [SUB_W-1:0]  subkey
);
    logic [CD_W-1:0]      cd_q;
    logic [CD_W-1:0]      cd_next;
    logic [CD_HALF_W-1:0] c_h;
    logic [CD_HALF_W-1:0] d_h;
    logic                 one_fwd;
    logic                 one_inv;

    always_comb begin
        c_h     = cd_q[CD_W-1:CD_HALF_W];
        d_h     = cd_q[CD_HALF_W-1:0];
        one_fwd = shift_is_one(rnd);
        one_inv = shift_is_one(4'd15 - rnd);
        if (dir == DIR_FWD) begin
            // Forward: rotate left first, the rotated value feeds this round.
            if (one_fwd) begin
                cd_next = {c_h[CD_HALF_W-2:0], c_h[CD_HALF_W-1],
                           d_h[CD_HALF_W-2:0], d_h[CD_HALF_W-1]};
            end else begin
                cd_next = {c_h[CD_HALF_W-3:0], c_h[CD_HALF_W-1:CD_HALF_W-2],
                           d_h[CD_HALF_W-3:0], d_h[CD_HALF_W-1:CD_HALF_W-2]};
            end
            subkey = choice2(cd_next);
        end else begin
            // Inverse: current value feeds this round, then rotate right.
            if (one_inv) begin
                cd_next = {c_h[0], c_h[CD_HALF_W-1:1], d_h[0], d_h[CD_HALF_W-1:1]};
            end else begin
                cd_next = {c_h[1:0], c_h[CD_HALF_W-1:2], d_h[1:0], d_h[CD_HALF_W-1:2]};
            end
            subkey = choice2(cd_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cd_q <= '0;
        end else if (load) begin
            cd_q <= choice1(load_key);
        end else if (step) begin
            cd_q <= cd_next;
        end
    end
endmodule

// File: rtl/tdea_ctrl.sv
module tdea_ctrl
    import tdea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              accept,
    output logic              pass_end,
    output logic              final_round,
    output logic [RND_W-1:0]  rnd,
    output logic [PASS_W-1:0] pass
);
    localparam logic [RND_W-1:0]  LAST_RND  = RND_W'(ROUNDS - 1);
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

    logic              busy_q;
    logic              done_q;
    logic [RND_W-1:0]  rnd_q;
    logic [PASS_W-1:0] pass_q;

    always_comb begin
        accept      = start && !busy_q;
        pass_end    = busy_q && (rnd_q == LAST_RND);
        final_round = pass_end && (pass_q == LAST_PASS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
            pass_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                rnd_q  <= '0;
                pass_q <= '0;
            end else if (busy_q) begin
                rnd_q <= rnd_q + 1'b1;
                if (final_round) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else if (pass_end) begin
                    pass_q <= pass_q + 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign rnd  = rnd_q;
    assign pass = pass_q;

    // R6: a running block always advances one round per cycle, start or not
    p_round_advance_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !final_round) |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1));

    // R8: the pass counter never leaves its range
    p_pass_range_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (pass_q <= LAST_PASS));
endmodule

// File: rtl/tdea_core.sv
module tdea_core
    import tdea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        decrypt,
    input  logic        three_key,
    input  logic [63:0] data_in,
    input  logic [63:0] key_a,
    input  logic [63:0] key_b,
    input  logic [63:0] key_c,
    output logic        busy,
    output logic        done,
    output logic [63:0] data_out
);
    localparam int STORED_KEYS = PASSES - 1;

    logic              accept;
    logic              pass_end;
    logic              final_round;
    logic [RND_W-1:0]  rnd;
    logic [PASS_W-1:0] pass;

    pass_dir_e         dir_q;
    pass_dir_e         pass_dir;
    halves_t           st_q;
    logic [BLK_W-1:0]  later_key_q [STORED_KEYS];
    logic [BLK_W-1:0]  third_key;
    logic [BLK_W-1:0]  first_key;
    logic [BLK_W-1:0]  ks_key;
    logic              ks_load;
    logic [SUB_W-1:0]  subkey;
    logic [HALF_W-1:0] f_val;

    tdea_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .busy        (busy),
        .done        (done),
        .accept      (accept),
        .pass_end    (pass_end),
        .final_round (final_round),
        .rnd         (rnd),
        .pass        (pass)
    );

    always_comb begin
        third_key = three_key ? key_c : key_a;
        first_key = decrypt ? third_key : key_a;
        // The middle pass runs opposite to the outer two.
        pass_dir  = (pass == PASS_W'(1)) ? pass_dir_e'(~dir_q) : dir_q;
        ks_load   = accept || (pass_end && !final_round);
        ks_key    = accept ? first_key : later_key_q[pass[0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_FWD;
            for (int i = 0; i < STORED_KEYS; i++) begin
                later_key_q[i] <= '0;
            end
        end else if (accept) begin
            dir_q          <= pass_dir_e'(decrypt);
            later_key_q[0] <= key_b;
            later_key_q[1] <= decrypt ? key_a : third_key;
        end
    end

    tdea_keysched u_keys (
        .clk      (clk),
        .rst      (rst),
        .load     (ks_load),
        .load_key (ks_key),
        .step     (busy),
        .dir      (pass_dir),
        .rnd      (rnd),
        .subkey   (subkey)
    );

    tdea_feistel u_round (
        .half_in (st_q.right),
        .subkey  (subkey),
        .f_out   (f_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (accept) begin
            st_q <= halves_t'(initial_perm(data_in));
        end else if (busy) begin
            if (pass_end) begin
                // Last round of a pass: no half swap, which hands the next pass its input.
                st_q.left  <= st_q.left ^ f_val;
            end else begin
                st_q.left  <= st_q.right;
                st_q.right <= st_q.left ^ f_val;
            end
        end
    end

    always_comb begin
        data_out = final_perm(st_q);
    end

    // R2: an idle engine seeing start becomes busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R7: done lasts a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done marks the end of a busy run
    p_done_end_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7: the result holds while idle and not restarted
    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(data_out));
endmodule

// File: tb/tdea_core_bench.sv
module tdea_core_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        decrypt;
    logic        three_key;
    logic [63:0] data_in;
    logic [63:0] key_a;
    logic [63:0] key_b;
    logic [63:0] key_c;
    logic        busy;
    logic        done;
    logic [63:0] data_out;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] KA = 64'h133457799BBCDFF1;
    localparam logic [63:0] PA = 64'h0123456789ABCDEF;
    localparam logic [63:0] CA = 64'h85E813540F0AB405;
    localparam logic [63:0] KB = 64'h0123456789ABCDEF;
    localparam logic [63:0] PB = 64'h4E6F772069732074;
    localparam logic [63:0] CB = 64'h3FA40E8A984D4815;
    localparam int LATENCY = 48;

    always #10 clk = ~clk;

    tdea_core u_tdea_core (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .decrypt   (decrypt),
        .three_key (three_key),
        .data_in   (data_in),
        .key_a     (key_a),
        .key_b     (key_b),
        .key_c     (key_c),
        .busy      (busy),
        .done      (done),
        .data_out  (data_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic launch(input logic [63:0] d, input logic [63:0] k1, input logic [63:0] k2,
                          input logic [63:0] k3, input logic three, input logic dec);
        @(negedge clk);
        data_in = d; key_a = k1; key_b = k2; key_c = k3;
        three_key = three; decrypt = dec; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!done && lat < 200);
    endtask

    task automatic run_op(input logic [63:0] d, input logic [63:0] k1, input logic [63:0] k2,
                          input logic [63:0] k3, input logic three, input logic dec,
                          output logic [63:0] res, output int lat);
        launch(d, k1, k2, k3, three, dec);
        wait_done(lat);
        res = data_out;
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; decrypt = 1'b0; three_key = 1'b1;
        data_in = '0; key_a = '0; key_b = '0; key_c = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R1 done after reset", 64'(done), 64'd0);
    endtask

    task automatic t_known_vectors();
        logic [63:0] r;
        int lat;
        run_op(PA, KA, KA, KA, 1'b1, 1'b0, r, lat);
        chk("R3 single-DES equivalent encrypt", r, CA);
        chk("R8 latency", 64'(lat), 64'(LATENCY));
        run_op(CA, KA, KA, KA, 1'b1, 1'b1, r, lat);
        chk("R9 single-DES equivalent decrypt", r, PA);
        run_op(PB, KB, KB, KB, 1'b1, 1'b0, r, lat);
        chk("R3 second vector", r, CB);
    endtask

    task automatic t_pass_order();
        logic [63:0] r;
        int lat;
        // K1=K2 cancels passes 1 and 2: only key 3 remains.
        run_op(PA, KB, KB, KA, 1'b1, 1'b0, r, lat);
        chk("R4 encrypt last pass uses key 3", r, CA);
        // K2=K3 cancels passes 2 and 3: only key 1 remains.
        run_op(PB, KB, KA, KA, 1'b1, 1'b0, r, lat);
        chk("R4 encrypt first pass uses key 1", r, CB);
        // Decrypt with K2=K3: only key 1 in the last pass remains.
        run_op(CB, KB, KA, KA, 1'b1, 1'b1, r, lat);
        chk("R4 decrypt last pass uses key 1", r, PB);
        // Decrypt with K1=K2: only key 3 in the first pass remains.
        run_op(CA, KB, KB, KA, 1'b1, 1'b1, r, lat);
        chk("R4 decrypt first pass uses key 3", r, PA);
    endtask

    task automatic t_two_key();
        logic [63:0] r;
        logic [63:0] r3;
        int lat;
        run_op(PA, KA, KA, 64'hFEDCBA9876543210, 1'b0, 1'b0, r, lat);
        chk("R5 two-key ignores key_c", r, CA);
        run_op(PB, KB, KA, 64'h5555AAAA5555AAAA, 1'b0, 1'b0, r, lat);
        run_op(PB, KB, KA, KB, 1'b1, 1'b0, r3, lat);
        chk("R5 two-key equals three-key with key_c=key_a", r, r3);
        run_op(r, KB, KA, 64'h0F0F0F0F0F0F0F0F, 1'b0, 1'b1, r3, lat);
        chk("R5 two-key decrypt", r3, PB);
    endtask

    task automatic t_roundtrip();
        logic [63:0] c;
        logic [63:0] p;
        int lat;
        for (int i = 0; i < 4; i++) begin
            logic [63:0] d;
            logic [63:0] k1;
            logic [63:0] k2;
            logic [63:0] k3;
            logic three;
            d  = 64'hA5A5_0000_FFFF_1234 ^ (64'(i) * 64'h1111_3333_5555_7777);
            k1 = 64'h0123_4567_89AB_CDEF + 64'(i);
            k2 = 64'hFEDC_BA98_7654_3210 ^ (64'(i) << 17);
            k3 = 64'h89AB_CDEF_0123_4567 - 64'(i * 3);
            three = i[0];
            run_op(d, k1, k2, k3, three, 1'b0, c, lat);
            run_op(c, k1, k2, k3, three, 1'b1, p, lat);
            chk($sformatf("R4 round trip %0d", i), p, d);
        end
    endtask

    task automatic t_busy_ignore();
        logic [63:0] r;
        int lat;
        launch(PA, KA, KA, KA, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        data_in = 64'hDEADBEEFDEADBEEF; key_a = KB; key_b = 64'h1; key_c = 64'h2;
        decrypt = 1'b1; three_key = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 21;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk("R6 result unaffected by mid-run inputs", data_out, CA);
        chk("R6 timing unaffected by mid-run start", 64'(lat), 64'(LATENCY));
        r = data_out;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done || busy) begin
                chk("R6 no restart from ignored start", 64'(1), 64'(0));
                break;
            end
        end
        chk("R7 result held while idle", data_out, r);
    endtask

    task automatic t_done_pulse();
        logic [63:0] r;
        int lat;
        run_op(PB, KB, KB, KB, 1'b1, 1'b0, r, lat);
        chk("R8 busy low with done", 64'(busy), 64'd0);
        @(negedge clk);
        chk("R7 done lasts one cycle", 64'(done), 64'd0);
        data_in = 64'h1234;
        repeat (5) @(negedge clk);
        chk("R7 data_out stable until next start", data_out, CB);
    endtask

    task automatic t_parity();
        logic [63:0] r;
        int lat;
        logic [63:0] flip;
        flip = 64'h0101010101010101;
        run_op(PA, KA ^ flip, KA ^ flip, KA ^ flip, 1'b1, 1'b0, r, lat);
        chk("R10 parity bits ignored", r, CA);
    endtask

    task automatic t_start_latency();
        int lat;
        launch(PB, KB, KB, KB, 1'b1, 1'b0);
        chk("R2 busy after accepted start", 64'(busy), 64'd1);
        wait_done(lat);
        chk("R2 accepted block finishes", data_out, CB);
    endtask

    initial begin
        t_reset();
        t_start_latency();
        t_known_vectors();
        t_pass_order();
        t_two_key();
        t_roundtrip();
        t_busy_ignore();
        t_done_pulse();
        t_parity();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

endmodule